// File: doc/BRIEF.md
# Motor Driver Sleep Sequencer

This block moves a stepper-driver core between full operation and a low-power sleep state. A single sleep flag held in a control register, written over the serial register path, requests the change. While asleep, the block forces the power-stage enables off so the outputs float. It holds the core clock gated except during a serial transfer, and it drops every step pulse and direction change. The control register keeps its value, and a hard clear is refused.

Clearing the sleep flag does not restore operation at once. The block first passes through a settling phase, whose length in clock cycles is loaded from an input when the phase begins, so the charge pump can come up. Only after that phase are step pulses forwarded to the core again. A step pulse that arrives while steps are barred is dropped and recorded in a sticky flag. A separate strobe clears that flag. Setting the sleep flag again during the settling phase sends the block straight back to sleep.

Top module: `drv_sleep_sequencer`

## Requirements
- R1: While `rst_n` is low and for two rising edges after it rises, `pwr_state_o` is 0 (run), `ctrl_o` is 0, `step_rejected_o` is 0 and `dir_o` is 0.
- R2: `pwr_state_o` encodes run=0, sleep=1, settle=2. A write to address 3 sets the control register at the next edge. With bit 7 of the register at 1, a block in run state enters sleep at the following edge.
- R3: `stage_en_o` equals `drv_en_i` in run state and is 0 in sleep and settle.
- R4: `core_clk_en_o` is 1 in run and settle, and equals `spi_busy_i` in sleep.
- R5: In sleep and settle, `step_o` is 0 and `dir_o` holds its value. In run, `step_o` follows `step_i`, and `dir_o` takes `dir_i` at each edge.
- R6: A `step_i` high in sleep or settle sets `step_rejected_o` at the next edge. The flag stays set until `rej_clr_i` (or an accepted hard clear) is high at an edge. When a rejected step and a clear meet at the same edge, the flag is set.
- R7: When bit 7 reads 0 in sleep, the block enters settle and loads `settle_cycles_i`. It then stays in settle for `settle_cycles_i`+1 cycles before returning to run.
- R8: If bit 7 reads 1 during settle, the block returns to sleep at the next edge.
- R9: In sleep the control register changes only through a write to address 3. Such writes are accepted in sleep.
- R10: In run or settle, `hard_clr_i` clears the control register and the rejected flag at the next edge. A hard clear takes priority over a write at the same edge. In sleep, `hard_clr_i` has no effect.
- R11: Writes to any address other than 3 leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| hard_clr_i | input | 1 | Hard clear request |
| settle_cycles_i | input | 16 | Charge-pump settling length in cycles |
| spi_busy_i | input | 1 | Serial transfer in progress |
| step_i | input | 1 | Step pulse from the command side |
| dir_i | input | 1 | Direction from the command side |
| drv_en_i | input | 1 | Power-stage enable request from the core |
| rej_clr_i | input | 1 | Clears the rejected-step flag |
| step_o | output | 1 | Gated step pulse to the core |
| dir_o | output | 1 | Held direction to the core |
| stage_en_o | output | 1 | Power-stage enable; 0 means high impedance |
| core_clk_en_o | output | 1 | Enable for the external core clock gate |
| step_rejected_o | output | 1 | Sticky flag for dropped step pulses |
| pwr_state_o | output | 2 | Current power state |
| ctrl_o | output | 8 | Control register contents |

## Verification
A behavioural model is compared with the outputs on every cycle while step pulses, direction toggles, serial-busy toggles and hard clears are applied in each of the three states. Doing this in every state separates the gating in run from the gating in sleep and settle. Exits with settling lengths of 5 and 0 expose any off-by-one in the settle count. A sleep request during a long settle shows whether the block returns straight to sleep or finishes settling first. A rejected step that coincides with the clear strobe, a hard clear given in sleep and then in run, and writes to a foreign address show the priority of set over clear, the refusal of a clear in sleep, and the address decode.

// File: rtl/drv_sleep_pkg.sv
package drv_sleep_pkg;
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_SLEEP  = 2'd1,
    PS_SETTLE = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/drv_rst_sync.sv
module drv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/drv_ctrl_reg.sv
module drv_ctrl_reg #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 3,
  parameter int SLEEP_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_eff,
  input  logic              in_sleep,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              sleep_req
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

  logic              wr_hit;
  logic              reg_en;
  logic [DATA_W-1:0] reg_d;

  assign wr_hit = wr_en && (wr_addr == HIT_ADDR);

  always_comb begin
    reg_en = 1'b0;
    reg_d  = ctrl_q;
    if (clr_eff) begin
      reg_en = 1'b1;
      reg_d  = '0;
    end else if (wr_hit) begin
      reg_en = 1'b1;
      reg_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (reg_en) ctrl_q <= reg_d;
  end

  assign sleep_req = ctrl_q[SLEEP_BIT];

  p_kept_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && !wr_hit) |=> $stable(ctrl_q));
  p_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_eff |=> (ctrl_q == '0));
  p_foreign_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit && !clr_eff) |=> $stable(ctrl_q));
endmodule

// File: rtl/drv_pwr_fsm.sv
module drv_pwr_fsm
  import drv_sleep_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [CNT_W-1:0] settle_cycles,
  output pwr_state_e       state_q
);
  pwr_state_e       state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      PS_RUN: begin
        if (sleep_req) state_d = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (!sleep_req) begin
          state_d = PS_SETTLE;
          cnt_d   = settle_cycles;
          cnt_en  = 1'b1;
        end
      end
      PS_SETTLE: begin
        if (sleep_req) begin
          state_d = PS_SLEEP;
        end else if (cnt_q == '0) begin
          state_d = PS_RUN;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  p_settle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SETTLE && !sleep_req && cnt_q != '0) |=> (state_q == PS_SETTLE));
  p_settle_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SETTLE && !sleep_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_resleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SETTLE && sleep_req) |=> (state_q == PS_SLEEP));
  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && sleep_req) |=> (state_q == PS_SLEEP));
endmodule

// File: rtl/drv_step_gate.sv
module drv_step_gate
  import drv_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state,
  input  logic       step_i,
  input  logic       dir_i,
  input  logic       rej_clr,
  input  logic       clr_eff,
  output logic       step_o,
  output logic       dir_q,
  output logic       rej_q
);
  logic run;
  logic rej_set;
  logic rej_en;
  logic rej_d;

  assign run     = (state == PS_RUN);
  assign step_o  = step_i & run;
  assign rej_set = step_i & ~run;

  always_comb begin
    rej_en = 1'b0;
    rej_d  = rej_q;
    if (rej_set) begin
      rej_en = 1'b1;
      rej_d  = 1'b1;
    end else if (rej_clr || clr_eff) begin
      rej_en = 1'b1;
      rej_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      if (run)    dir_q <= dir_i;
      if (rej_en) rej_q <= rej_d;
    end
  end

  p_no_step_barred_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_RUN) |-> !step_o);
  p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PS_RUN) |=> $stable(dir_q));
  p_reject_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && state != PS_RUN) |=> rej_q);
  p_reject_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_q && !rej_clr && !clr_eff) |=> rej_q);
endmodule

// File: rtl/drv_sleep_sequencer.sv
module drv_sleep_sequencer
  import drv_sleep_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int CTRL_ADDR = 3,
  parameter int SLEEP_BIT = 7,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              hard_clr_i,
  input  logic [CNT_W-1:0]  settle_cycles_i,
  input  logic              spi_busy_i,
  input  logic              step_i,
  input  logic              dir_i,
  input  logic              drv_en_i,
  input  logic              rej_clr_i,
  output logic              step_o,
  output logic              dir_o,
  output logic              stage_en_o,
  output logic              core_clk_en_o,
  output logic              step_rejected_o,
  output logic [1:0]        pwr_state_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic       rst_n_int;
  logic       sleep_req;
  logic       in_sleep;
  logic       clr_eff;
  pwr_state_e state;

  drv_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign in_sleep = (state == PS_SLEEP);
  assign clr_eff  = hard_clr_i & ~in_sleep;

  drv_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .SLEEP_BIT(SLEEP_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .clr_eff   (clr_eff),
    .in_sleep  (in_sleep),
    .ctrl_q    (ctrl_o),
    .sleep_req (sleep_req)
  );

  drv_pwr_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .sleep_req     (sleep_req),
    .settle_cycles (settle_cycles_i),
    .state_q       (state)
  );

  drv_step_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .state   (state),
    .step_i  (step_i),
    .dir_i   (dir_i),
    .rej_clr (rej_clr_i),
    .clr_eff (clr_eff),
    .step_o  (step_o),
    .dir_q   (dir_o),
    .rej_q   (step_rejected_o)
  );

  assign stage_en_o      = drv_en_i & (state == PS_RUN);
  assign core_clk_en_o   = ~in_sleep | spi_busy_i;
  assign pwr_state_o     = 2'(state);

  p_hiz_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pwr_state_o != 2'd0) |-> !stage_en_o);
  p_clk_gated_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pwr_state_o == 2'd1 && !spi_busy_i) |-> !core_clk_en_o);
  p_clk_live_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pwr_state_o != 2'd1) |-> core_clk_en_o);
endmodule

// File: tb/drv_sleep_sequencer_test.sv
module drv_sleep_sequencer_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        hard_clr;
  logic [15:0] settle;
  logic        spi_busy;
  logic        step;
  logic        dir;
  logic        drv_en;
  logic        rej_clr;
  logic        step_o;
  logic        dir_o;
  logic        stage_en_o;
  logic        core_clk_en_o;
  logic        step_rejected_o;
  logic [1:0]  pwr_state_o;
  logic [7:0]  ctrl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_state, m_ctrl, m_cnt, m_rej, m_dir, m_rel;

  drv_sleep_sequencer uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hard_clr_i(hard_clr), .settle_cycles_i(settle), .spi_busy_i(spi_busy),
    .step_i(step), .dir_i(dir), .drv_en_i(drv_en), .rej_clr_i(rej_clr),
    .step_o(step_o), .dir_o(dir_o), .stage_en_o(stage_en_o), .core_clk_en_o(core_clk_en_o),
    .step_rejected_o(step_rejected_o), .pwr_state_o(pwr_state_o), .ctrl_o(ctrl_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: register, power state, settle countdown, flag, direction.
  always @(posedge clk or negedge rst_n) begin : model
    int sleeping, sbit, nxt;
    if (!rst_n) begin
      m_state = 0; m_ctrl = 0; m_cnt = 0; m_rej = 0; m_dir = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      sleeping = (m_state == 1);
      sbit     = (m_ctrl >> 7) & 1;
      nxt      = m_state;
      if (m_state == 0) begin
        if (sbit != 0) nxt = 1;
      end else if (m_state == 1) begin
        if (sbit == 0) begin nxt = 2; m_cnt = settle; end
      end else begin
        if (sbit != 0) nxt = 1;
        else if (m_cnt == 0) nxt = 0;
        else m_cnt--;
      end
      if (step && m_state != 0) m_rej = 1;
      else if (rej_clr || (hard_clr && !sleeping)) m_rej = 0;
      if (m_state == 0) m_dir = dir;
      if (hard_clr && !sleeping) m_ctrl = 0;
      else if (wr_en && wr_addr == 4'd3) m_ctrl = wr_data;
      m_state = nxt;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R2 state", pwr_state_o, m_state);
      chk("R9 ctrl", ctrl_o, m_ctrl);
      chk("R6 rejected", step_rejected_o, m_rej);
      chk("R5 dir", dir_o, m_dir);
      chk("R5 step", step_o, (step && m_state == 0) ? 1 : 0);
      chk("R3 stage_en", stage_en_o, (drv_en && m_state == 0) ? 1 : 0);
      chk("R4 clk_en", core_clk_en_o, (m_state != 1 || spi_busy) ? 1 : 0);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse_step();
    @(negedge clk); #1 step = 1'b1;
    @(negedge clk); #1 step = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic count_settle(input logic [15:0] len, input int exp);
    int n;
    n = 0;
    settle = len;
    wr(4'd3, 8'h00);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwr_state_o == 2'd2) n++;
    end
    #1;
    chk("R7 settle length", n, exp);
    chk("R7 back in run", pwr_state_o, 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; hard_clr = 0; settle = 16'd3;
    spi_busy = 0; step = 0; dir = 0; drv_en = 0; rej_clr = 0;
    idle(3);
    chk("R1 reset state", pwr_state_o, 0);
    chk("R1 reset ctrl", ctrl_o, 0);
    #1 rst_n = 1'b1;
    wr(4'd3, 8'h80);
    chk("R1 write ignored during release", ctrl_o, 0);
    idle(3);

    // Run state: enables, steps and direction pass.
    drv_en = 1; dir = 1;
    pulse_step();
    idle(2);
    chk("R5 dir taken in run", dir_o, 1);
    spi_busy = 1; idle(1); spi_busy = 0;

    // Foreign address ignored.
    wr(4'd2, 8'hFF);
    wr(4'd4, 8'h80);
    chk("R11 foreign write", ctrl_o, 0);

    // Enter sleep.
    wr(4'd3, 8'h80);
    idle(1);
    chk("R2 asleep", pwr_state_o, 1);
    chk("R3 stage hiz", stage_en_o, 0);
    dir = 0;
    pulse_step();
    idle(1);
    chk("R6 flag set in sleep", step_rejected_o, 1);
    chk("R5 dir held in sleep", dir_o, 1);
    spi_busy = 1; idle(2);
    chk("R4 clk on for transfer", core_clk_en_o, 1);
    spi_busy = 0; idle(1);
    chk("R4 clk gated", core_clk_en_o, 0);
    hard_clr = 1; idle(1); hard_clr = 0; idle(1);
    chk("R10 clear ignored in sleep", ctrl_o, 8'h80);
    chk("R10 flag kept in sleep", step_rejected_o, 1);
    wr(4'd3, 8'h85);
    chk("R9 write in sleep", ctrl_o, 8'h85);
    chk("R9 still asleep", pwr_state_o, 1);

    // Set wins over clear, then clear alone.
    @(negedge clk); #1 step = 1; rej_clr = 1;
    @(negedge clk); #1 step = 0; rej_clr = 0;
    chk("R6 set beats clear", step_rejected_o, 1);
    @(negedge clk); #1 rej_clr = 1;
    @(negedge clk); #1 rej_clr = 0;
    chk("R6 cleared", step_rejected_o, 0);

    // Exit with settle 5 and 0.
    count_settle(16'd5, 6);
    wr(4'd3, 8'h80); idle(2);
    count_settle(16'd0, 1);

    // Step during settle, then sleep request during settle.
    wr(4'd3, 8'h80); idle(2);
    settle = 16'd20;
    wr(4'd3, 8'h00);
    idle(2);
    chk("R7 in settle", pwr_state_o, 2);
    pulse_step();
    chk("R6 flag in settle", step_rejected_o, 1);
    wr(4'd3, 8'h80);
    idle(1);
    chk("R8 back to sleep", pwr_state_o, 1);
    settle = 16'd2;
    wr(4'd3, 8'h00);
    idle(8);
    chk("R7 run again", pwr_state_o, 0);

    // Hard clear in run, beating a same-cycle write.
    wr(4'd3, 8'h41);
    @(negedge clk); #1 hard_clr = 1; wr_en = 1; wr_addr = 4'd3; wr_data = 8'h22;
    @(negedge clk); #1 hard_clr = 0; wr_en = 0;
    chk("R10 clear in run", ctrl_o, 0);
    chk("R10 flag cleared", step_rejected_o, 0);
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule